// File: doc/BRIEF.md
# Offset Command Serial Framer and Receiver

This block carries offset-adjust and reset commands for one digitiser channel group over a slow asynchronous serial line. On the transmit side it takes one command through a valid/ready handshake: a 7-bit converter identifier, a flag that turns the command into a reset, and a 16-bit offset value. It wraps these into a fixed seven-character message and shifts it out one bit at a time, with each bit lasting `OVS` clocks. The clock therefore runs at `OVS` times the line rate, which means 800 MHz for a 100 Mb/s line at the default of 8.

On the receive side it watches an incoming line of the same format and oversamples it at the same rate. It rebuilds the characters, parses the message and checks the framing, the length and the checksum. A good message produces a one-cycle strobe with the decoded fields. A bad one produces a one-cycle error strobe and is thrown away.

Top module: `ofs_cmd_link`

## Requirements
- R1: After reset `ser_out` is 1, `cmd_ready` is 1, and `rx_valid` and `rx_err` are 0. The line is always 1 while no message is being sent.
- R2: Each character on `ser_out` is one 0 bit, then data bits 0 to 7 (least significant first), then two 1 bits. Every bit lasts `OVS` clocks, and the first bit starts in the cycle after the command is accepted.
- R3: A message is seven characters with no idle time between them, in this order: A5h, length 03h, identifier byte, offset high byte, offset low byte, checksum, 55h. In the identifier byte, bit 7 is the reset flag (1 = reset, 0 = offset command) and bits 6:0 are the converter identifier.
- R4: The checksum is the sum, modulo 256, of the length byte and the three body bytes.
- R5: `cmd_ready` goes low at acceptance and comes back high exactly 77·`OVS` clocks later. While it is low, `cmd_valid` and the command inputs have no effect on the line.
- R6: A well-formed message on `ser_in` gives exactly one single-cycle `rx_valid` pulse. With it, `rx_adc` carries bits 6:0 of the identifier byte, `rx_rst` carries its bit 7, and `rx_value` carries the high and low bytes joined. Measured from the start of the first character, the pulse comes no earlier than 76·`OVS` clocks and no later than 79·`OVS` clocks.
- R7: A message whose checksum character does not match the sum rule of R4 gives one `rx_err` pulse and no `rx_valid`.
- R8: A message whose last character is not 55h gives one `rx_err` pulse and no `rx_valid`.
- R9: If either stop bit of any character is sampled as 0, the receiver gives one `rx_err` pulse and drops the message in progress. It then waits for the line to return to 1 and accepts the next well-formed message.
- R10: A length character other than 03h gives one `rx_err` pulse. The rest of that message produces no further pulse.
- R11: While no message is open, characters other than A5h are ignored and produce neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `OVS` times the line bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Transmitter idle, command can be taken |
| cmd_adc | input | 7 | Converter identifier |
| cmd_rst | input | 1 | 1 = reset command, 0 = offset command |
| cmd_value | input | 16 | Offset value |
| ser_out | output | 1 | Serial line out, idles at 1 |
| ser_in | input | 1 | Serial line in, asynchronous |
| rx_valid | output | 1 | One-cycle strobe for a good message |
| rx_err | output | 1 | One-cycle strobe for a rejected message |
| rx_adc | output | 7 | Received converter identifier |
| rx_rst | output | 1 | Received reset flag |
| rx_value | output | 16 | Received offset value |

## Verification
Bit g of a transmitted message (counting from 0 at the first start bit) is on `ser_out` from `g·OVS` to `(g+1)·OVS−1` clocks after the accepting edge. The bench counts edges from acceptance and samples each bit at `g·OVS + OVS/2`, mid-bit and well away from any transition. `cmd_ready` is sampled one clock before and at the 77·`OVS` mark, so the exact return of readiness is checked. Receive results come through two synchroniser flops and a mid-bit sampler, so they are checked against a window of 76 to 79 bit periods. Results of stimulus driven by the bench bit by bit are counted only after a quiet gap of several characters.

// File: rtl/ofs_cmd_link.sv
module ofs_cmd_link #(
  parameter int OVS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [6:0]  cmd_adc,
  input  logic        cmd_rst,
  input  logic [15:0] cmd_value,
  output logic        ser_out,
  input  logic        ser_in,
  output logic        rx_valid,
  output logic        rx_err,
  output logic [6:0]  rx_adc,
  output logic        rx_rst,
  output logic [15:0] rx_value
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] TOP = CW'(OVS - 1);
  localparam logic [CW-1:0] MID = CW'(OVS / 2 - 1);
  localparam logic [7:0] SOF = 8'hA5;
  localparam logic [7:0] EOF = 8'h55;
  localparam logic [7:0] LEN = 8'd3;
  localparam logic [3:0] LAST_BIT = 4'd10;
  localparam logic [2:0] LAST_CHR = 3'd6;

  // transmit
  logic          tx_busy, tx_line;
  logic [CW-1:0] tx_tick;
  logic [3:0]    tx_bit;
  logic [2:0]    tx_idx;
  logic [7:0]    tx_id, tx_hi, tx_lo, tx_sum, tx_byte;
  logic          accept;

  assign accept    = cmd_valid && !tx_busy;
  assign cmd_ready = !tx_busy;
  assign ser_out   = tx_line;
  assign tx_sum    = LEN + tx_id + tx_hi + tx_lo;

  always_comb begin
    case (tx_idx)
      3'd0:    tx_byte = SOF;
      3'd1:    tx_byte = LEN;
      3'd2:    tx_byte = tx_id;
      3'd3:    tx_byte = tx_hi;
      3'd4:    tx_byte = tx_lo;
      3'd5:    tx_byte = tx_sum;
      default: tx_byte = EOF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_line <= 1'b1;
      tx_tick <= '0;
      tx_bit  <= '0;
      tx_idx  <= '0;
      tx_id   <= '0;
      tx_hi   <= '0;
      tx_lo   <= '0;
    end else if (accept) begin
      tx_busy <= 1'b1;
      tx_line <= 1'b0;
      tx_tick <= '0;
      tx_bit  <= '0;
      tx_idx  <= '0;
      tx_id   <= {cmd_rst, cmd_adc};
      tx_hi   <= cmd_value[15:8];
      tx_lo   <= cmd_value[7:0];
    end else if (tx_busy) begin
      if (tx_tick == TOP) begin
        tx_tick <= '0;
        if (tx_bit == LAST_BIT) begin
          if (tx_idx == LAST_CHR) begin
            tx_busy <= 1'b0;
            tx_line <= 1'b1;
          end else begin
            tx_idx  <= tx_idx + 3'd1;
            tx_bit  <= '0;
            tx_line <= 1'b0;
          end
        end else begin
          tx_bit  <= tx_bit + 4'd1;
          tx_line <= (tx_bit < 4'd8) ? tx_byte[tx_bit[2:0]] : 1'b1;
        end
      end else begin
        tx_tick <= tx_tick + CW'(1);
      end
    end
  end

  // receive: line sampler
  typedef enum logic [1:0] {R_IDLE, R_RUN, R_WHI} rx_state_e;
  rx_state_e     rx_st;
  logic          s1, s2;
  logic [CW-1:0] rx_tick;
  logic [3:0]    rx_bit;
  logic [7:0]    rx_sh;
  logic          samp, got_byte, stop_bad;

  assign samp     = (rx_st == R_RUN) && ((rx_bit == 4'd0) ? (rx_tick == MID) : (rx_tick == TOP));
  assign got_byte = samp && (rx_bit == LAST_BIT) && s2;
  assign stop_bad = samp && (rx_bit >= 4'd9) && !s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= ser_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st   <= R_IDLE;
      rx_tick <= '0;
      rx_bit  <= '0;
      rx_sh   <= '0;
    end else begin
      case (rx_st)
        R_IDLE: if (!s2) begin
          rx_st   <= R_RUN;
          rx_tick <= '0;
          rx_bit  <= '0;
        end
        R_RUN: if (!samp) begin
          rx_tick <= rx_tick + CW'(1);
        end else begin
          rx_tick <= '0;
          rx_bit  <= rx_bit + 4'd1;
          if (rx_bit == 4'd0) begin
            if (s2) rx_st <= R_IDLE;
          end else if (rx_bit <= 4'd8) begin
            rx_sh <= {s2, rx_sh[7:1]};
          end else if (!s2) begin
            rx_st <= R_WHI;
          end else if (rx_bit == LAST_BIT) begin
            rx_st <= R_IDLE;
          end
        end
        default: if (s2) rx_st <= R_IDLE;
      endcase
    end
  end

  // receive: message parser
  logic [2:0] ps;
  logic [7:0] rx_sum, p_id, p_hi, p_lo;
  logic       sum_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps       <= '0;
      rx_sum   <= '0;
      p_id     <= '0;
      p_hi     <= '0;
      p_lo     <= '0;
      sum_ok   <= 1'b0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      rx_adc   <= '0;
      rx_rst   <= 1'b0;
      rx_value <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (stop_bad) begin
        rx_err <= 1'b1;
        ps     <= '0;
      end else if (got_byte) begin
        case (ps)
          3'd0: if (rx_sh == SOF) ps <= 3'd1;
          3'd1: if (rx_sh == LEN) begin
            rx_sum <= rx_sh;
            ps     <= 3'd2;
          end else begin
            rx_err <= 1'b1;
            ps     <= '0;
          end
          3'd2: begin p_id <= rx_sh; rx_sum <= rx_sum + rx_sh; ps <= 3'd3; end
          3'd3: begin p_hi <= rx_sh; rx_sum <= rx_sum + rx_sh; ps <= 3'd4; end
          3'd4: begin p_lo <= rx_sh; rx_sum <= rx_sum + rx_sh; ps <= 3'd5; end
          3'd5: begin sum_ok <= (rx_sh == rx_sum); ps <= 3'd6; end
          default: begin
            ps <= '0;
            if (rx_sh == EOF && sum_ok) begin
              rx_valid <= 1'b1;
              rx_adc   <= p_id[6:0];
              rx_rst   <= p_id[7];
              rx_value <= {p_hi, p_lo};
            end else begin
              rx_err <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ofs_cmd_link_chk.sv
module ofs_cmd_link_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic ser_out,
  input logic rx_valid,
  input logic rx_err
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> ser_out);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !ser_out);
  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err));
endmodule

bind ofs_cmd_link ofs_cmd_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .ser_out(ser_out), .rx_valid(rx_valid), .rx_err(rx_err)
);

// File: tb/ofs_cmd_link_test.sv
module ofs_cmd_link_test;
  localparam int OVS = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 190000;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_rst = 0;
  logic [6:0] cmd_adc = '0;
  logic [15:0] cmd_value = '0;
  logic cmd_ready, ser_out, ser_in, rx_valid, rx_err, rx_rst;
  logic [6:0] rx_adc;
  logic [15:0] rx_value;
  logic loop_sel = 1, bb_line = 1;

  assign ser_in = loop_sel ? ser_out : bb_line;

  ofs_cmd_link #(.OVS(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_adc(cmd_adc), .cmd_rst(cmd_rst), .cmd_value(cmd_value), .ser_out(ser_out),
    .ser_in(ser_in), .rx_valid(rx_valid), .rx_err(rx_err), .rx_adc(rx_adc),
    .rx_rst(rx_rst), .rx_value(rx_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int total = 0, bad = 0;
  int vcnt = 0, ecnt = 0, vstamp = 0;
  logic [6:0] vadc;
  logic vrst;
  logic [15:0] vval;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin vcnt++; vstamp = cyc; vadc = rx_adc; vrst = rx_rst; vval = rx_value; end
    if (rx_err) ecnt++;
  end

  always @(posedge clk) if (cyc == WD_LIMIT) begin
    bad++;
    $display("FAIL watchdog (all requirements) actual=%0d cycles expected=finish earlier", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [6:0] a, input logic r, input logic [15:0] v, input bit poke);
    logic [7:0] eb [7];
    logic [10:0] ch;
    int e, v0, e0;
    bit rdy_bad;
    eb = '{8'hA5, 8'h03, {r, a}, v[15:8], v[7:0], 8'h03 + {r, a} + v[15:8] + v[7:0], 8'h55};
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_adc = a; cmd_rst = r; cmd_value = v; cmd_valid = 1;
    v0 = vcnt; e0 = ecnt; rdy_bad = 0;
    @(negedge clk);
    e = cyc;
    cmd_valid = 0;
    for (int c = 0; c < 7; c++) begin
      for (int k = 0; k < 11; k++) begin
        int g = c * 11 + k;
        wait_to(e + g * OVS + OVS / 2);
        ch[k] = ser_out;
        if (cmd_ready) rdy_bad = 1;
        if (poke && g == 1) begin cmd_valid = 1; cmd_adc = ~a; cmd_rst = ~r; cmd_value = ~v; end
        if (poke && g == 70) cmd_valid = 0;
      end
      // R2 character shape, R3 order, R4 checksum
      chk(ch[0] == 1'b0 && ch[10:9] == 2'b11 && ch[8:1] == eb[c],
          $sformatf("R2/R3/R4 char %0d", c), {1'b0, ch}, {2'b11, eb[c], 1'b0});
    end
    chk(!rdy_bad, "R5 ready low during message", rdy_bad, 0);
    wait_to(e + 77 * OVS - 1);
    chk(cmd_ready == 1'b0, "R5 ready one clock before end", cmd_ready, 0);
    wait_to(e + 77 * OVS);
    chk(cmd_ready == 1'b1, "R5 ready at 77 bit times", cmd_ready, 1);
    wait_to(e + 80 * OVS);
    chk(vcnt == v0 + 1 && ecnt == e0, "R6 one valid, no error", vcnt - v0, 1);
    chk(vadc == a && vrst == r && vval == v, "R6 decoded fields",
        {vrst, vadc, vval}, {r, a, v});
    chk(vstamp - e >= 76 * OVS && vstamp - e <= 79 * OVS, "R6 latency window",
        vstamp - e, 77 * OVS);
  endtask

  task automatic bb_byte(input logic [7:0] b, input int bad_stop);
    for (int k = 0; k < 11; k++) begin
      if (k == 0) bb_line = 0;
      else if (k <= 8) bb_line = b[k-1];
      else bb_line = !((k == 9 && bad_stop == 1) || (k == 10 && bad_stop == 2));
      repeat (OVS) @(negedge clk);
    end
  endtask

  task automatic bb_frame(input logic [7:0] id, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] len, input logic [7:0] cks_delta,
                          input logic [7:0] eof, input int bad_pos, input int bad_stop);
    logic [7:0] fb [7];
    bit stop;
    fb = '{8'hA5, len, id, hi, lo, len + id + hi + lo + cks_delta, eof};
    stop = 0;
    for (int c = 0; c < 7; c++) begin
      if (!stop) begin
        bb_byte(fb[c], (c == bad_pos) ? bad_stop : 0);
        if (c == bad_pos) stop = 1;
      end
    end
    bb_line = 1;
    repeat (30 * OVS) @(negedge clk);
  endtask

  task automatic expect_counts(input int v0, input int e0, input int dv, input int de, input string tag);
    chk(vcnt - v0 == dv && ecnt - e0 == de, tag, {16'(vcnt - v0), 16'(ecnt - e0)}, {16'(dv), 16'(de)});
  endtask

  initial begin
    logic [6:0] ids [4];
    logic [15:0] vals [5];
    int v0, e0;
    ids = '{7'h00, 7'h01, 7'h2A, 7'h7F};
    vals = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8001, 16'hA5A5};
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ser_out == 1 && cmd_ready == 1 && rx_valid == 0 && rx_err == 0, "R1 reset state",
        {ser_out, cmd_ready, rx_valid, rx_err}, 4'b1100);

    // loopback sweep, one message with inputs toggled while busy (R5)
    for (int i = 0; i < 4; i++)
      for (int r = 0; r < 2; r++)
        for (int v = 0; v < 5; v++)
          send_cmd(ids[i], r[0], vals[v], (i == 2 && r == 1 && v == 3));

    loop_sel = 0;
    bb_line = 1;
    repeat (4 * OVS) @(negedge clk);

    // R11 stray characters outside a message
    v0 = vcnt; e0 = ecnt;
    bb_byte(8'h12, 0);
    bb_byte(8'h55, 0);
    bb_byte(8'h03, 0);
    repeat (20 * OVS) @(negedge clk);
    expect_counts(v0, e0, 0, 0, "R11 stray characters ignored");

    v0 = vcnt; e0 = ecnt;
    bb_frame(8'h83, 8'h4C, 8'h21, 8'h03, 8'h00, 8'h55, -1, 0);
    expect_counts(v0, e0, 1, 0, "R6 driven message accepted");
    chk(vadc == 7'h03 && vrst == 1'b1 && vval == 16'h4C21, "R6 driven fields",
        {vrst, vadc, vval}, {1'b1, 7'h03, 16'h4C21});

    v0 = vcnt; e0 = ecnt;
    bb_frame(8'h11, 8'h22, 8'h33, 8'h03, 8'h01, 8'h55, -1, 0);
    expect_counts(v0, e0, 0, 1, "R7 checksum mismatch");

    v0 = vcnt; e0 = ecnt;
    bb_frame(8'h11, 8'h22, 8'h33, 8'h03, 8'h00, 8'h54, -1, 0);
    expect_counts(v0, e0, 0, 1, "R8 wrong end character");

    v0 = vcnt; e0 = ecnt;
    bb_frame(8'h05, 8'h10, 8'h20, 8'h04, 8'h00, 8'h55, -1, 0);
    expect_counts(v0, e0, 0, 1, "R10 wrong length");

    v0 = vcnt; e0 = ecnt;
    bb_frame(8'h07, 8'h10, 8'h20, 8'h03, 8'h00, 8'h55, 3, 1);
    expect_counts(v0, e0, 0, 1, "R9 first stop bit low");

    v0 = vcnt; e0 = ecnt;
    bb_frame(8'h07, 8'h10, 8'h20, 8'h03, 8'h00, 8'h55, 5, 2);
    expect_counts(v0, e0, 0, 1, "R9 second stop bit low");

    v0 = vcnt; e0 = ecnt;
    bb_frame(8'h7E, 8'hBE, 8'hEF, 8'h03, 8'h00, 8'h55, -1, 0);
    expect_counts(v0, e0, 1, 0, "R9 recovery after stop error");
    chk(vadc == 7'h7E && vrst == 1'b0 && vval == 16'hBEEF, "R9 recovered fields",
        {vrst, vadc, vval}, {1'b0, 7'h7E, 16'hBEEF});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule